// File: doc/BRIEF.md
# Daisy-Chain Readout Token Sequencer

This block sequences the readout of one front-end chip that shares its serial readout lines with other chips on a daisy chain. The chip stays quiet until its trigger unit reports a first-level hit. After that hit the sequencer waits for a second-level accept from the acquisition system. Only then does it claim the next token that arrives on the chain. If it holds data, it steps an analogue multiplexer select through all its slots, one per readout clock. In step with that select it shifts one digital bit per clock onto the serial line, and it hands the token on during the last slot. If the trigger unit reports no data, it suppresses its output and hands the token on after a single clock.

The block runs on the readout clock itself. When no accept arrives within a programmable number of readout clocks, the hit is dropped: the sequencer pulses a clear request to the trigger unit and returns to rest. A token that passes by while the chip has no accepted event (at rest, or armed but not yet accepted) is relayed one clock later without any change of state. This keeps the chain moving for the other chips.

Top module: `rdo_token_seq`

## Requirements
- R1: While the reset input is low, and after it is released, tok_out, ser_out, clr_req and mux_sel are all 0 and the sequencer is at rest. Asserting reset takes effect without waiting for a clock.
- R2: A token (tok_in high for one clock) that arrives while the sequencer is at rest or armed is relayed as tok_out high on the following clock only. The sequencer's own state is unchanged.
- R3: A trig_hit pulse arms the sequencer only when it is at rest. A trig_hit that arrives during a readout is ignored.
- R4: An accept while armed moves the sequencer to wait for the token. An accept at rest is ignored.
- R5: If no accept arrives, clr_req is high for exactly one clock, the TMO_CYC-th clock spent armed. The sequencer is then at rest.
- R6: An accept that falls on that final armed clock wins over the timeout. clr_req stays 0 and the sequencer waits for the token.
- R7: When a token arrives while waiting and has_data is 1, hit_bits is captured on that clock. For the next NSLOT clocks, mux_sel counts 0,1,…,NSLOT-1 and ser_out carries the captured word least significant bit first.
- R8: During a readout, tok_out is high only during the clock with mux_sel = NSLOT-1. After that the sequencer is at rest.
- R9: When a token arrives while waiting and has_data is 0, tok_out is high for exactly the next clock and ser_out stays 0.
- R10: Outside a readout, ser_out and mux_sel are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_hit | input | 1 | First-level hit pulse from the trigger unit |
| has_data | input | 1 | Trigger unit holds digital hit data |
| hit_bits | input | NSLOT | Digital hit word to shift out |
| accept | input | 1 | Second-level accept from acquisition |
| tok_in | input | 1 | Token from the previous chip |
| tok_out | output | 1 | Token to the next chip |
| ser_out | output | 1 | Serial digital data |
| mux_sel | output | $clog2(NSLOT) | Analogue multiplexer channel select |
| clr_req | output | 1 | Request to the trigger unit to discard its data |

## Verification
Two pairs of events can fall in the same clock. The first pair is the accept and the timeout expiry. The bench drives accept exactly on the TMO_CYC-th armed clock and expects no clear request, followed by a full readout on the next token. The second pair is a trigger and a passing token. Both are driven together at rest, and the bench expects the token to be relayed on the next clock while the sequencer still arms. A later accept and token then produce a full readout, which proves the sequencer was armed.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_PASS  = 3'd4
  } rdo_st_e;
endpackage

// File: rtl/rdo_rst_sync.sv
module rdo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_i_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_i_n = sync_q[1];
endmodule

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
  import rdo_pkg::*;
#(
  parameter int TMO_CYC = 16
) (
  input  logic    clk,
  input  logic    rst_i_n,
  input  logic    trig_hit,
  input  logic    accept,
  input  logic    tok_in,
  input  logic    has_data,
  input  logic    last_slot,
  output rdo_st_e st_q,
  output logic    load,
  output logic    byp_q,
  output logic    clr_req
);
  localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  rdo_st_e     st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic        tmr_en;
  logic        tmo_hit;
  logic        byp_d;

  assign tmo_hit = (st_q == ST_ARMED) && (tmr_q == TMO_LAST);
  assign clr_req = tmo_hit && !accept;
  assign load    = (st_q == ST_WAIT) && tok_in && has_data;
  assign byp_d   = tok_in && ((st_q == ST_IDLE) || (st_q == ST_ARMED));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (trig_hit) st_d = ST_ARMED;
      ST_ARMED: begin
        if (accept)       st_d = ST_WAIT;
        else if (tmo_hit) st_d = ST_IDLE;
      end
      ST_WAIT:  if (tok_in) st_d = has_data ? ST_SHIFT : ST_PASS;
      ST_SHIFT: if (last_slot) st_d = ST_IDLE;
      ST_PASS:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign tmr_en = (st_q == ST_ARMED) || (tmr_q != '0);

  always_comb begin
    if (st_d == ST_ARMED && st_q == ST_ARMED) tmr_d = tmr_q + 1'b1;
    else                                       tmr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q  <= ST_IDLE;
      byp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      byp_q <= byp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end
endmodule

// File: rtl/rdo_shifter.sv
module rdo_shifter #(
  parameter int NSLOT = 8,
  localparam int SELW = $clog2(NSLOT)
) (
  input  logic            clk,
  input  logic            rst_i_n,
  input  logic            load,
  input  logic            shift_en,
  input  logic [NSLOT-1:0] din,
  output logic [SELW-1:0] cnt_q,
  output logic            bit_out,
  output logic            last_slot
);
  localparam logic [SELW-1:0] LAST = SELW'(NSLOT - 1);

  logic [NSLOT-1:0] sreg_q, sreg_d;
  logic [SELW-1:0]  cnt_d;
  logic             en;

  assign en = load || shift_en;

  always_comb begin
    if (load) begin
      sreg_d = din;
      cnt_d  = '0;
    end else begin
      sreg_d = {1'b0, sreg_q[NSLOT-1:1]};
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
    end
  end

  assign bit_out   = sreg_q[0];
  assign last_slot = shift_en && (cnt_q == LAST);
endmodule

// File: rtl/rdo_token_seq.sv
module rdo_token_seq
  import rdo_pkg::*;
#(
  parameter int NSLOT   = 8,
  parameter int TMO_CYC = 16,
  localparam int SELW   = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_hit,
  input  logic             has_data,
  input  logic [NSLOT-1:0] hit_bits,
  input  logic             accept,
  input  logic             tok_in,
  output logic             tok_out,
  output logic             ser_out,
  output logic [SELW-1:0]  mux_sel,
  output logic             clr_req
);
  logic            rst_i_n;
  rdo_st_e         st_q;
  logic            load;
  logic            byp_q;
  logic            last_slot;
  logic            in_shift;
  logic [SELW-1:0] cnt_q;
  logic            bit_out;

  rdo_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_i_n (rst_i_n)
  );

  rdo_ctrl #(.TMO_CYC(TMO_CYC)) u_ctrl (
    .clk       (clk),
    .rst_i_n   (rst_i_n),
    .trig_hit  (trig_hit),
    .accept    (accept),
    .tok_in    (tok_in),
    .has_data  (has_data),
    .last_slot (last_slot),
    .st_q      (st_q),
    .load      (load),
    .byp_q     (byp_q),
    .clr_req   (clr_req)
  );

  assign in_shift = (st_q == ST_SHIFT);

  rdo_shifter #(.NSLOT(NSLOT)) u_shf (
    .clk       (clk),
    .rst_i_n   (rst_i_n),
    .load      (load),
    .shift_en  (in_shift),
    .din       (hit_bits),
    .cnt_q     (cnt_q),
    .bit_out   (bit_out),
    .last_slot (last_slot)
  );

  assign tok_out = byp_q || (st_q == ST_PASS) || last_slot;
  assign ser_out = in_shift && bit_out;
  assign mux_sel = in_shift ? cnt_q : '0;
endmodule

// File: rtl/rdo_token_seq_chk.sv
module rdo_token_seq_chk
  import rdo_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int SELW = $clog2(NSLOT)
) (
  input logic            clk,
  input logic            rst_i_n,
  input rdo_st_e         st_q,
  input logic            tok_in,
  input logic            tok_out,
  input logic            has_data,
  input logic            accept,
  input logic            ser_out,
  input logic            clr_req,
  input logic [SELW-1:0] mux_sel
);
  localparam logic [SELW-1:0] LAST = SELW'(NSLOT - 1);

  AST_IDLE_RELAY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_IDLE && tok_in) |=> tok_out);  // R2

  AST_ACCEPT_ARMS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_ARMED && accept) |=> (st_q == ST_WAIT));  // R4

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    clr_req |=> (!clr_req && st_q == ST_IDLE));  // R5

  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_SHIFT && mux_sel != LAST) |=>
      (st_q == ST_SHIFT && mux_sel == SELW'($past(mux_sel) + 1'b1)));  // R7

  AST_LAST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_SHIFT && tok_out) |=> (st_q == ST_IDLE && !tok_out));  // R8

  AST_EMPTY_PASS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_WAIT && tok_in && !has_data) |=> (tok_out && !ser_out));  // R9
endmodule

bind rdo_token_seq rdo_token_seq_chk #(.NSLOT(NSLOT)) u_chk (
  .clk      (clk),
  .rst_i_n  (rst_i_n),
  .st_q     (st_q),
  .tok_in   (tok_in),
  .tok_out  (tok_out),
  .has_data (has_data),
  .accept   (accept),
  .ser_out  (ser_out),
  .clr_req  (clr_req),
  .mux_sel  (mux_sel)
);

// File: tb/rdo_token_seq_bench.sv
module rdo_token_seq_bench;
  localparam int NSLOT = 8;
  localparam int TMO   = 16;

  typedef struct {
    int         cyc;
    bit         tok;
    bit         ser;
    bit [2:0]   sel;
    bit         clr;
    string      req;
  } exp_t;

  logic clk, rst_n, trig_hit, has_data, accept, tok_in;
  logic [7:0] hit_bits;
  logic tok_out, ser_out, clr_req;
  logic [2:0] mux_sel;

  int total = 0, bad = 0, cyc_p = 0;
  bit finished = 0;
  exp_t sb_q[$];
  exp_t cur;

  rdo_token_seq #(.NSLOT(NSLOT), .TMO_CYC(TMO)) u_rdo_token_seq (
    .clk(clk), .rst_n(rst_n), .trig_hit(trig_hit), .has_data(has_data),
    .hit_bits(hit_bits), .accept(accept), .tok_in(tok_in), .tok_out(tok_out),
    .ser_out(ser_out), .mux_sel(mux_sel), .clr_req(clr_req)
  );

  initial clk = 0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc_p <= cyc_p + 1;

  task automatic expect_at(input int c, input bit tok, input bit ser,
                           input bit [2:0] sel, input bit clr, input string r);
    exp_t e;
    e.cyc = c; e.tok = tok; e.ser = ser; e.sel = sel; e.clr = clr; e.req = r;
    sb_q.push_back(e);
  endtask

  task automatic expect_shift(input int c, input logic [7:0] w);
    for (int i = 0; i < 8; i++)
      expect_at(c + i, (i == 7), w[i], 3'(i), 1'b0, (i == 7) ? "R8" : "R7");
  endtask

  task automatic at_cyc(input int c);
    @(negedge clk);
    while (cyc_p < c) @(negedge clk);
  endtask

  // monitor: sample 5 ns before the rising edge
  always @(negedge clk) begin
    #5;
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc_p) begin
      cur = sb_q.pop_front();
      total++;
      if (cur.cyc < cyc_p) begin
        bad++;
        $display("FAIL %s: item for cycle %0d not sampled (now %0d)", cur.req, cur.cyc, cyc_p);
      end else if (tok_out !== cur.tok || ser_out !== cur.ser ||
                   mux_sel !== cur.sel || clr_req !== cur.clr) begin
        bad++;
        $display("FAIL %s cyc %0d: tok/ser/sel/clr got %b/%b/%0d/%b exp %b/%b/%0d/%b",
                 cur.req, cyc_p, tok_out, ser_out, mux_sel, clr_req,
                 cur.tok, cur.ser, cur.sel, cur.clr);
      end
    end
  end

  task automatic direct_idle_check(input string r);
    total++;
    if (tok_out !== 1'b0 || ser_out !== 1'b0 || mux_sel !== 3'd0 || clr_req !== 1'b0) begin
      bad++;
      $display("FAIL %s: tok/ser/sel/clr got %b/%b/%0d/%b exp 0/0/0/0",
               r, tok_out, ser_out, mux_sel, clr_req);
    end
  endtask

  initial begin
    int b;
    rst_n = 0; trig_hit = 0; has_data = 0; accept = 0; tok_in = 0; hit_bits = 8'h00;
    repeat (3) @(negedge clk);
    #5 direct_idle_check("R1");
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    #5 direct_idle_check("R1");

    // S1: token passes at rest (R2, R10)
    b = cyc_p + 2;
    expect_at(b + 1, 1, 0, 0, 0, "R2");
    expect_at(b + 2, 0, 0, 0, 0, "R10");
    at_cyc(b); tok_in = 1;
    at_cyc(b + 1); tok_in = 0;

    // S2: full readout, capture at token, trigger during readout ignored (R3, R4, R7, R8)
    b = cyc_p + 3;
    has_data = 1; hit_bits = 8'hA5;
    expect_at(b + 2, 0, 0, 0, 0, "R10");
    expect_shift(b + 4, 8'hA5);
    expect_at(b + 12, 0, 0, 0, 0, "R8");
    expect_at(b + 14, 1, 0, 0, 0, "R3");
    expect_at(b + 15, 0, 0, 0, 0, "R3");
    at_cyc(b); trig_hit = 1;
    at_cyc(b + 1); trig_hit = 0; accept = 1;
    at_cyc(b + 2); accept = 0;
    at_cyc(b + 3); tok_in = 1;
    at_cyc(b + 4); tok_in = 0;
    at_cyc(b + 5); hit_bits = 8'h00;
    at_cyc(b + 6); trig_hit = 1;
    at_cyc(b + 7); trig_hit = 0;
    at_cyc(b + 12); accept = 1;
    at_cyc(b + 13); accept = 0; tok_in = 1; hit_bits = 8'hFF;
    at_cyc(b + 14); tok_in = 0;

    // S3: empty chip, zero suppression (R9)
    b = cyc_p + 3;
    has_data = 0; hit_bits = 8'hFF;
    expect_at(b + 4, 1, 0, 0, 0, "R9");
    expect_at(b + 5, 0, 0, 0, 0, "R9");
    at_cyc(b); trig_hit = 1;
    at_cyc(b + 1); trig_hit = 0; accept = 1;
    at_cyc(b + 2); accept = 0;
    at_cyc(b + 3); tok_in = 1;
    at_cyc(b + 4); tok_in = 0;

    // S4: timeout clears and returns to rest (R5, R4)
    b = cyc_p + 3;
    has_data = 1; hit_bits = 8'hFF;
    expect_at(b + 15, 0, 0, 0, 0, "R5");
    expect_at(b + 16, 0, 0, 0, 1, "R5");
    expect_at(b + 17, 0, 0, 0, 0, "R5");
    expect_at(b + 19, 1, 0, 0, 0, "R4");
    expect_at(b + 20, 0, 0, 0, 0, "R4");
    at_cyc(b); trig_hit = 1;
    at_cyc(b + 1); trig_hit = 0;
    at_cyc(b + 17); accept = 1;
    at_cyc(b + 18); accept = 0; tok_in = 1;
    at_cyc(b + 19); tok_in = 0;

    // S5: accept on the final armed clock wins (R6)
    b = cyc_p + 3;
    hit_bits = 8'h3C;
    expect_at(b + 16, 0, 0, 0, 0, "R6");
    expect_at(b + 17, 0, 0, 0, 0, "R6");
    expect_shift(b + 18, 8'h3C);
    at_cyc(b); trig_hit = 1;
    at_cyc(b + 1); trig_hit = 0;
    at_cyc(b + 16); accept = 1;
    at_cyc(b + 17); accept = 0; tok_in = 1;
    at_cyc(b + 18); tok_in = 0;
    at_cyc(b + 27);

    // S6: trigger and token in the same clock at rest (R2, R3)
    b = cyc_p + 3;
    hit_bits = 8'h81;
    expect_at(b + 1, 1, 0, 0, 0, "R2");
    expect_shift(b + 4, 8'h81);
    at_cyc(b); trig_hit = 1; tok_in = 1;
    at_cyc(b + 1); trig_hit = 0; tok_in = 0; accept = 1;
    at_cyc(b + 2); accept = 0;
    at_cyc(b + 3); tok_in = 1;
    at_cyc(b + 4); tok_in = 0;
    at_cyc(b + 13);

    // S7: token relayed while armed, state kept (R2)
    b = cyc_p + 3;
    hit_bits = 8'h5E;
    expect_at(b + 3, 1, 0, 0, 0, "R2");
    expect_at(b + 4, 0, 0, 0, 0, "R2");
    expect_shift(b + 6, 8'h5E);
    at_cyc(b); trig_hit = 1;
    at_cyc(b + 1); trig_hit = 0;
    at_cyc(b + 2); tok_in = 1;
    at_cyc(b + 3); tok_in = 0; accept = 1;
    at_cyc(b + 4); accept = 0;
    at_cyc(b + 5); tok_in = 1;
    at_cyc(b + 6); tok_in = 0;
    at_cyc(b + 15);

    // S8: asynchronous reset in mid-readout (R1)
    b = cyc_p + 3;
    hit_bits = 8'hFF;
    expect_at(b + 4, 0, 1, 0, 0, "R7");
    at_cyc(b); trig_hit = 1;
    at_cyc(b + 1); trig_hit = 0; accept = 1;
    at_cyc(b + 2); accept = 0;
    at_cyc(b + 3); tok_in = 1;
    at_cyc(b + 4); tok_in = 0;
    at_cyc(b + 6); rst_n = 0;
    #2 direct_idle_check("R1");
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    #5 direct_idle_check("R1");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule